// File: doc/BRIEF.md
# Synthesizer Lock Interrupt and Recovery Controller

This block sits beside a radio transceiver's state machine and watches the synthesizer lock indicator. It raises two sticky interrupt flags, one for lock and one for lock loss. Each flag clears the other when it is set, so at most one is pending at a time. A combined interrupt line is formed from the flags and a per-flag mask. Software clears both flags with a read-clear strobe.

The block also knows which transceiver state is active. In the idle synthesizer-on state and the receive-on state, frequency retunes and manual calibrations are announced as a lock loss followed by a relock. A lock loss while a frame is in flight makes the block request a recovery state from the transceiver state machine. A transmit is aborted at once. A receive is returned to its listening state only after the synthesizer has locked again.

Top module: `pll_irq_ctrl`

## Requirements
- R1: After reset, `irq_flags_o` is 0, `irq_o` is 0 and `req_valid_o` is 0.
- R2: The raw lock input passes through a two-stage synchronizer. A rise of `lock_raw_i` sets flag bit 0 (lock) on the third rising clock edge after the change, and a fall sets flag bit 1 (unlock) on that same third edge, whatever the state.
- R3: The two flag bits are never 1 together. Setting either flag clears the other.
- R4: A `freq_chg_i` or `cal_start_i` pulse sets the unlock flag on the next edge, but only while `trx_state_i` is synth-idle (5'h09) or receive-on (5'h06). In every other state the pulse changes nothing.
- R5: A `cal_done_i` pulse in synth-idle or receive-on sets the lock flag on the next edge. In every other state it changes nothing.
- R6: A change of `trx_state_i` from off (5'h08) to synth-idle or receive-on while the synchronized lock is high sets the lock flag two edges after the state change.
- R7: When a lock-set event and an unlock-set event occur in the same cycle, the unlock flag wins.
- R8: The flags hold until `irq_clr_i`, which clears both on the next edge. A set event in the same cycle as the clear still sets its flag.
- R9: `irq_o` is high exactly when (flags AND `irq_mask_i`) is non-zero. Mask bit 0 gates the lock flag and mask bit 1 gates the unlock flag.
- R10: A synchronized lock fall in busy-transmit (5'h02) or busy-transmit-with-retry (5'h12) gives a one-cycle `req_valid_o` with `req_state_o` = synth-idle (5'h09), on the same edge that sets the unlock flag.
- R11: A lock fall in busy-receive (5'h01) is held pending. A lock fall in busy-receive-with-auto-ack (5'h11) is also held pending. On relock the block issues a one-cycle request on the same edge that sets the lock flag: receive-on (5'h06) for busy-receive, or receive-with-auto-ack-on (5'h16) for busy-receive-with-auto-ack.
- R12: A pending receive request is dropped if `trx_state_i` leaves the two busy-receive states before relock. No request follows the relock.
- R13: A lock fall or rise in any state not named in R10 or R11 issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_raw_i | input | 1 | Unsynchronized synthesizer lock level |
| trx_state_i | input | 5 | Current transceiver state code |
| freq_chg_i | input | 1 | Frequency-setting change strobe |
| cal_start_i | input | 1 | Manual calibration start strobe |
| cal_done_i | input | 1 | Manual calibration done strobe |
| irq_mask_i | input | 2 | Per-flag interrupt enable |
| irq_clr_i | input | 1 | Read-clear strobe for both flags |
| irq_flags_o | output | 2 | Bit 0 lock, bit 1 unlock |
| irq_o | output | 1 | Masked OR of the flags |
| req_valid_o | output | 1 | One-cycle state-return request |
| req_state_o | output | 5 | Requested next state code |

## Verification
The bench sweeps every defined state code through a lock loss and a relock, and through each strobe. A design that decodes states loosely would request recovery from the wrong states, or report retunes outside the two idle-on states. Directed cases cover the following:
- a receive that leaves busy before relock, where a missing cancel produces a stray request;
- a lock-set event and an unlock-set event in the same cycle, where the wrong priority leaves the lock flag set;
- a set event that meets a clear, where the event would otherwise be lost;
- an off-to-on transition while already locked, which has no lock edge and so needs the armed path.

// File: rtl/pll_irq_pkg.sv
package pll_irq_pkg;
  parameter int unsigned STATE_W = 5;
  typedef logic [STATE_W-1:0] trx_state_t;

  localparam trx_state_t ST_OFF         = 5'h08;
  localparam trx_state_t ST_SYN_IDLE    = 5'h09;
  localparam trx_state_t ST_RX_ON       = 5'h06;
  localparam trx_state_t ST_RX_ACK_ON   = 5'h16;
  localparam trx_state_t ST_BUSY_RX     = 5'h01;
  localparam trx_state_t ST_BUSY_RX_ACK = 5'h11;
  localparam trx_state_t ST_BUSY_TX     = 5'h02;
  localparam trx_state_t ST_BUSY_TX_RTY = 5'h12;

  localparam int unsigned NUM_FLAGS   = 2;
  localparam int unsigned FLAG_LOCK   = 0;
  localparam int unsigned FLAG_UNLOCK = 1;

  function automatic logic is_on_idle(trx_state_t s);
    return (s == ST_SYN_IDLE) || (s == ST_RX_ON);
  endfunction

  function automatic logic is_busy_tx(trx_state_t s);
    return (s == ST_BUSY_TX) || (s == ST_BUSY_TX_RTY);
  endfunction

  function automatic logic is_busy_rx(trx_state_t s);
    return (s == ST_BUSY_RX) || (s == ST_BUSY_RX_ACK);
  endfunction
endpackage

// File: rtl/pll_irq_sync.sv
module pll_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_raw_i,
  output logic lock_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = lock_raw_i;
    end else begin : g_next
      assign d = chain_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= 1'b0;
      else         chain_q[i] <= d;
    end
  end

  assign lock_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= lock_o;
  end

  assign rise_o = lock_o & ~last_q;
  assign fall_o = ~lock_o & last_q;

  // R2: an edge lasts exactly one cycle
  a_r2_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/pll_irq_flags.sv
module pll_irq_flags
  import pll_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  trx_state_t           state_i,
  input  logic                 lock_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 freq_chg_i,
  input  logic                 cal_start_i,
  input  logic                 cal_done_i,
  input  logic                 clr_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  trx_state_t            state_q;
  logic                  arm_q, arm_d;
  logic                  lock_set, unlock_set;
  logic [NUM_FLAGS-1:0]  flags_q, flags_d;

  // off -> on transition arms a lock report that fires once lock is present
  always_comb begin
    arm_d = arm_q;
    if (state_i == ST_OFF)                                   arm_d = 1'b0;
    else if (state_q == ST_OFF && is_on_idle(state_i))       arm_d = 1'b1;
    else if (arm_q && lock_i)                                arm_d = 1'b0;
  end

  assign lock_set   = rise_i | (cal_done_i & is_on_idle(state_i)) | (arm_q & lock_i);
  assign unlock_set = fall_i | ((freq_chg_i | cal_start_i) & is_on_idle(state_i));

  always_comb begin
    flags_d = flags_q;
    if (clr_i) flags_d = '0;
    if (unlock_set) begin
      flags_d[FLAG_UNLOCK] = 1'b1;
      flags_d[FLAG_LOCK]   = 1'b0;
    end else if (lock_set) begin
      flags_d[FLAG_LOCK]   = 1'b1;
      flags_d[FLAG_UNLOCK] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      arm_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      state_q <= state_i;
      arm_q   <= arm_d;
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_q[FLAG_LOCK] && flags_q[FLAG_UNLOCK]));
  a_r7_unlock_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_set |=> (flags_o[FLAG_UNLOCK] && !flags_o[FLAG_LOCK]));
  a_r8_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && lock_set && !unlock_set) |=> flags_o[FLAG_LOCK]);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !lock_set && !unlock_set) |=> (flags_o == '0));
endmodule

// File: rtl/pll_irq_recover.sv
module pll_irq_recover
  import pll_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  trx_state_t state_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       req_valid_o,
  output trx_state_t req_state_o
);
  logic       pend_q, pend_d;
  trx_state_t pend_state_q, pend_state_d;
  logic       valid_q, valid_d;
  trx_state_t state_q, state_d;

  always_comb begin
    pend_d       = pend_q;
    pend_state_d = pend_state_q;
    valid_d      = 1'b0;
    state_d      = state_q;
    if (pend_q && !is_busy_rx(state_i)) pend_d = 1'b0;
    if (fall_i) begin
      if (is_busy_tx(state_i)) begin
        valid_d = 1'b1;
        state_d = ST_SYN_IDLE;
      end else if (state_i == ST_BUSY_RX) begin
        pend_d       = 1'b1;
        pend_state_d = ST_RX_ON;
      end else if (state_i == ST_BUSY_RX_ACK) begin
        pend_d       = 1'b1;
        pend_state_d = ST_RX_ACK_ON;
      end
    end else if (rise_i && pend_q && is_busy_rx(state_i)) begin
      valid_d = 1'b1;
      state_d = pend_state_q;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_state_q <= ST_RX_ON;
      valid_q      <= 1'b0;
      state_q      <= ST_SYN_IDLE;
    end else begin
      pend_q       <= pend_d;
      pend_state_q <= pend_state_d;
      valid_q      <= valid_d;
      state_q      <= state_d;
    end
  end

  assign req_valid_o = valid_q;
  assign req_state_o = state_q;

  a_r10_tx_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && is_busy_tx(state_i)) |=> (req_valid_o && req_state_o == ST_SYN_IDLE));
  a_r11_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  a_r12_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !is_busy_rx(state_i) && !fall_i) |=> !req_valid_o);
endmodule

// File: rtl/pll_irq_ctrl.sv
module pll_irq_ctrl
  import pll_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lock_raw_i,
  input  logic [STATE_W-1:0]   trx_state_i,
  input  logic                 freq_chg_i,
  input  logic                 cal_start_i,
  input  logic                 cal_done_i,
  input  logic [NUM_FLAGS-1:0] irq_mask_i,
  input  logic                 irq_clr_i,
  output logic [NUM_FLAGS-1:0] irq_flags_o,
  output logic                 irq_o,
  output logic                 req_valid_o,
  output logic [STATE_W-1:0]   req_state_o
);
  logic lock_s, lock_rise, lock_fall;

  pll_irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_raw_i (lock_raw_i),
    .lock_o     (lock_s),
    .rise_o     (lock_rise),
    .fall_o     (lock_fall)
  );

  pll_irq_flags i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (trx_state_i),
    .lock_i      (lock_s),
    .rise_i      (lock_rise),
    .fall_i      (lock_fall),
    .freq_chg_i  (freq_chg_i),
    .cal_start_i (cal_start_i),
    .cal_done_i  (cal_done_i),
    .clr_i       (irq_clr_i),
    .flags_o     (irq_flags_o)
  );

  pll_irq_recover i_recover (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (trx_state_i),
    .rise_i      (lock_rise),
    .fall_i      (lock_fall),
    .req_valid_o (req_valid_o),
    .req_state_o (req_state_o)
  );

  assign irq_o = |(irq_flags_o & irq_mask_i);

  // R9: line follows flags and mask
  a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_i == '0) |-> !irq_o);
endmodule

// File: tb/test_pll_irq_ctrl.sv
module test_pll_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_raw = 1'b0;
  logic [4:0] state = 5'h08;
  logic       freq_chg = 1'b0, cal_start = 1'b0, cal_done = 1'b0;
  logic [1:0] mask = 2'b11;
  logic       clr = 1'b0;
  logic [1:0] flags;
  logic       irq;
  logic       req_valid;
  logic [4:0] req_state;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  pll_irq_ctrl i_pll_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lock_raw_i(lock_raw), .trx_state_i(state),
    .freq_chg_i(freq_chg), .cal_start_i(cal_start), .cal_done_i(cal_done),
    .irq_mask_i(mask), .irq_clr_i(clr), .irq_flags_o(flags), .irq_o(irq),
    .req_valid_o(req_valid), .req_state_o(req_state)
  );

  always #10 clk = ~clk;

  localparam logic [4:0] CODES [8] = '{5'h08, 5'h09, 5'h06, 5'h16, 5'h01, 5'h11, 5'h02, 5'h12};

  function automatic logic on_idle(logic [4:0] s);
    return s == 5'h09 || s == 5'h06;
  endfunction
  function automatic logic tx_busy(logic [4:0] s);
    return s == 5'h02 || s == 5'h12;
  endfunction
  function automatic logic [4:0] rx_ret(logic [4:0] s);
    return (s == 5'h01) ? 5'h06 : (s == 5'h11) ? 5'h16 : 5'h00;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_lock(logic v);
    lock_raw = v;
    tick();
    tick();
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    tick();
    clr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 flags", flags, 2'b00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 req", req_valid, 1'b0);
    rst_n = 1'b1;
    tick();

    // R2 latency: flag on third edge
    lock_raw = 1'b1;
    tick(); chk("R2 no flag edge1", flags, 2'b00);
    tick(); chk("R2 no flag edge2", flags, 2'b00);
    tick(); chk("R2 lock flag edge3", flags, 2'b01);
    tick(); chk("R8 sticky", flags, 2'b01);
    clear_flags();
    chk("R8 clear", flags, 2'b00);

    // R6 off -> on while locked
    state = 5'h06;
    tick(); chk("R6 not yet", flags, 2'b00);
    tick(); chk("R6 lock flag", flags, 2'b01);
    state = 5'h08; tick();
    clear_flags();

    // R10 R11 R13 sweep of lock loss and relock
    foreach (CODES[i]) begin
      logic [4:0] s = CODES[i];
      state = s;
      tick(); tick(); tick();
      clear_flags();
      set_lock(1'b0);
      tick();
      chk("R2 R3 unlock flag", flags, 2'b10);
      chk("R10 R13 req on loss", req_valid, tx_busy(s));
      if (tx_busy(s)) chk("R10 req state", req_state, 5'h09);
      tick();
      chk("R11 single pulse", req_valid, 1'b0);
      set_lock(1'b1);
      tick();
      chk("R3 lock flag clears unlock", flags, 2'b01);
      chk("R11 R13 req on relock", req_valid, rx_ret(s) != 5'h00);
      if (rx_ret(s) != 5'h00) chk("R11 req state", req_state, rx_ret(s));
      tick();
    end

    // R4 R5 strobe sweep
    foreach (CODES[i]) begin
      logic [4:0] s = CODES[i];
      state = (s == 5'h08) ? 5'h16 : s;
      tick(); tick(); tick();
      clear_flags();
      freq_chg = 1'b1; tick(); freq_chg = 1'b0;
      chk("R4 freq change", flags, on_idle(state) ? 2'b10 : 2'b00);
      clear_flags();
      cal_start = 1'b1; tick(); cal_start = 1'b0;
      chk("R4 cal start", flags, on_idle(state) ? 2'b10 : 2'b00);
      cal_done = 1'b1; tick(); cal_done = 1'b0;
      chk("R5 cal done", flags, on_idle(state) ? 2'b01 : 2'b00);
      clear_flags();
    end

    // R7 simultaneous set events
    state = 5'h09;
    freq_chg = 1'b1; cal_done = 1'b1; tick(); freq_chg = 1'b0; cal_done = 1'b0;
    chk("R7 unlock wins", flags, 2'b10);

    // R8 set beats clear
    cal_done = 1'b1; clr = 1'b1; tick(); cal_done = 1'b0; clr = 1'b0;
    chk("R8 set beats clear", flags, 2'b01);

    // R9 mask sweep on both flags
    for (int f = 0; f < 2; f++) begin
      clear_flags();
      if (f == 0) cal_done = 1'b1; else freq_chg = 1'b1;
      tick(); cal_done = 1'b0; freq_chg = 1'b0;
      for (int m = 0; m < 4; m++) begin
        mask = m[1:0];
        #1;
        chk("R9 irq", irq, m[f]);
      end
    end
    mask = 2'b11;
    clear_flags();

    // R12 cancel pending receive return
    state = 5'h11; tick();
    set_lock(1'b0); tick();
    state = 5'h16; tick();
    state = 5'h11;
    set_lock(1'b1); tick();
    chk("R12 no request after cancel", req_valid, 1'b0);
    chk("R12 lock flag still set", flags, 2'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule